// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block keeps a signed accumulator twice the data width, held as a high half and a low half. Two accumulate operations are supported. The long operation multiplies two full-width signed operands. The word operation multiplies the sign-extended lower half of each operand. In both cases the product is added to the accumulator.

A saturation input is sampled together with each operation and selects how the sum is clipped. The two operations clip differently. The long operation confines the high half to a signed band below its upper half. The word operation clamps to the signed single-word range and flags an overflow by setting the high half to one.

Operations enter through a one-cycle `start` strobe and may be issued on every cycle. The multiply is registered, and the sum is written on the following edge. At that point a one-cycle `done` pulse accompanies the new accumulator value. Software-style clear and per-half load controls write the accumulator directly.

Top module: `sat_mac_unit`

## Requirements
- R1: After reset, `acc_hi`, `acc_lo` and `done` are all zero.
- R2: With `op_sel`=0 (long) and saturation off, the full signed product of `opnd_a` and `opnd_b` is added to the signed value {acc_hi, acc_lo}, wrapping modulo 2^(2·DATA_W).
- R3: With `op_sel`=1 (word), only bits [DATA_W/2-1:0] of each operand are used, sign-extended; changing the upper operand bits leaves the result unchanged.
- R4: A `start` sampled at clock edge k makes `done` high for exactly the cycle after edge k+1, with the updated accumulator visible in that same cycle; starts on consecutive cycles each accumulate in order.
- R5: Long operation with saturation on and a negative sum: bits [DATA_W-1:DATA_W/2] of `acc_hi` are forced to one, and all other bits come from the sum.
- R6: Long operation with saturation on and a non-negative sum: bits [DATA_W-1:DATA_W/2-1] of `acc_hi` are cleared, and all other bits come from the sum.
- R7: Word operation with saturation on and a sum below -2^(DATA_W-1): `acc_hi` becomes 1 and `acc_lo` becomes 2^(DATA_W-1).
- R8: Word operation with saturation on and a sum above 2^(DATA_W-1)-1: `acc_hi` becomes 1 and `acc_lo` becomes 2^(DATA_W-1)-1. A sum inside that range is written unchanged.
- R9: `clr` zeroes both halves on the next edge. It takes priority over loads and over a pending accumulate, and `done` stays low in that cycle.
- R10: `ld_hi`/`ld_lo` write `ld_hi_data`/`ld_lo_data` into their half, leaving the other half unchanged. A load in the cycle an accumulate would be written discards that accumulate, and `done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle strobe issuing an accumulate |
| op_sel | input | 1 | 0 = long operation, 1 = word operation |
| sat_en | input | 1 | Saturation mode for the issued operation |
| opnd_a | input | DATA_W | First multiplicand |
| opnd_b | input | DATA_W | Second multiplicand |
| clr | input | 1 | Zero the whole accumulator |
| ld_hi | input | 1 | Write `ld_hi_data` into the high half |
| ld_lo | input | 1 | Write `ld_lo_data` into the low half |
| ld_hi_data | input | DATA_W | Load value for the high half |
| ld_lo_data | input | DATA_W | Load value for the low half |
| done | output | 1 | One-cycle pulse: accumulate result visible |
| acc_hi | output | DATA_W | High half of the accumulator |
| acc_lo | output | DATA_W | Low half of the accumulator |

## Verification
The accumulator halves are driven straight from state registers, so a wrong saturation branch, sign extension or carry between halves shows on `acc_hi`/`acc_lo` in the same cycle that `done` rises. That is two edges after `start`. A fault in the operand or mode pipeline register appears as a result computed with the wrong mode, or as a misplaced `done` pulse, within those two cycles. Because the accumulator feeds back into every later sum, a single wrong write also corrupts every following result until a load or clear.

// File: rtl/sat_mac_pkg.sv
package sat_mac_pkg;
  typedef enum logic {
    OP_LONG = 1'b0,
    OP_WORD = 1'b1
  } mac_op_e;
endpackage

// File: rtl/sat_mac_rst_sync.sv
module sat_mac_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/sat_mac_mult.sv
module sat_mac_mult
  import sat_mac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  mac_op_e               op,
  input  logic                  sat,
  input  logic [DATA_W-1:0]     a,
  input  logic [DATA_W-1:0]     b,
  output logic [2*DATA_W-1:0]   prod_q,
  output mac_op_e               op_q,
  output logic                  sat_q,
  output logic                  vld_q
);
  localparam int ACC_W  = 2 * DATA_W;
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] a_sel, b_sel;
  logic [ACC_W-1:0]  a_ext, b_ext, prod_d;

  // operand width selection: word mode keeps the sign-extended lower half
  always_comb begin
    if (op == OP_WORD) begin
      a_sel = {{HALF_W{a[HALF_W-1]}}, a[HALF_W-1:0]};
      b_sel = {{HALF_W{b[HALF_W-1]}}, b[HALF_W-1:0]};
    end else begin
      a_sel = a;
      b_sel = b;
    end
    a_ext  = {{DATA_W{a_sel[DATA_W-1]}}, a_sel};
    b_ext  = {{DATA_W{b_sel[DATA_W-1]}}, b_sel};
    prod_d = a_ext * b_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      op_q   <= OP_LONG;
      sat_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= start;
      if (start) begin
        prod_q <= prod_d;
        op_q   <= op;
        sat_q  <= sat;
      end
    end
  end
endmodule

// File: rtl/sat_mac_clip.sv
module sat_mac_clip
  import sat_mac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]   acc_hi,
  input  logic [DATA_W-1:0]   acc_lo,
  input  logic [2*DATA_W-1:0] prod,
  input  mac_op_e             op,
  input  logic                sat,
  output logic [DATA_W-1:0]   hi_o,
  output logic [DATA_W-1:0]   lo_o
);
  localparam int ACC_W  = 2 * DATA_W;
  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] NEG_SET  = {{HALF_W{1'b1}}, {HALF_W{1'b0}}};
  localparam logic [DATA_W-1:0] POS_KEEP = {{(HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] WORD_MIN = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] WORD_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] OVF_MARK = DATA_W'(1);

  logic [ACC_W-1:0] sum;
  logic             neg;
  logic             fits_word;

  always_comb begin
    sum       = {acc_hi, acc_lo} + prod;
    neg       = sum[ACC_W-1];
    // a value fits a signed word when all bits from DATA_W-1 upward agree
    fits_word = (sum[ACC_W-1:DATA_W-1] == '0) || (sum[ACC_W-1:DATA_W-1] == '1);
    hi_o      = sum[ACC_W-1:DATA_W];
    lo_o      = sum[DATA_W-1:0];
    if (sat) begin
      if (op == OP_LONG) begin
        if (neg) hi_o = sum[ACC_W-1:DATA_W] | NEG_SET;
        else     hi_o = sum[ACC_W-1:DATA_W] & POS_KEEP;
      end else if (!fits_word) begin
        hi_o = OVF_MARK;
        lo_o = neg ? WORD_MIN : WORD_MAX;
      end
    end
  end
endmodule

// File: rtl/sat_mac_unit.sv
module sat_mac_unit
  import sat_mac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_sel,
  input  logic              sat_en,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              clr,
  input  logic              ld_hi,
  input  logic              ld_lo,
  input  logic [DATA_W-1:0] ld_hi_data,
  input  logic [DATA_W-1:0] ld_lo_data,
  output logic              done,
  output logic [DATA_W-1:0] acc_hi,
  output logic [DATA_W-1:0] acc_lo
);
  localparam int ACC_W  = 2 * DATA_W;
  localparam int HALF_W = DATA_W / 2;

  logic              rst_sync_n;
  logic [ACC_W-1:0]  prod_q;
  mac_op_e           op_q;
  logic              sat_q;
  logic              vld_q;
  logic [DATA_W-1:0] clip_hi, clip_lo;
  logic [DATA_W-1:0] hi_q, lo_q, hi_d, lo_d;
  logic              done_q, done_d;
  logic              acc_en;
  mac_op_e           op_in;

  assign op_in = mac_op_e'(op_sel);

  sat_mac_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sat_mac_mult #(.DATA_W(DATA_W)) u_mult (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .start  (start),
    .op     (op_in),
    .sat    (sat_en),
    .a      (opnd_a),
    .b      (opnd_b),
    .prod_q (prod_q),
    .op_q   (op_q),
    .sat_q  (sat_q),
    .vld_q  (vld_q)
  );

  sat_mac_clip #(.DATA_W(DATA_W)) u_clip (
    .acc_hi (hi_q),
    .acc_lo (lo_q),
    .prod   (prod_q),
    .op     (op_q),
    .sat    (sat_q),
    .hi_o   (clip_hi),
    .lo_o   (clip_lo)
  );

  // next state: clear beats loads, loads beat the accumulate writeback
  always_comb begin
    hi_d   = hi_q;
    lo_d   = lo_q;
    done_d = 1'b0;
    acc_en = clr | ld_hi | ld_lo | vld_q;
    if (clr) begin
      hi_d = '0;
      lo_d = '0;
    end else if (ld_hi || ld_lo) begin
      if (ld_hi) hi_d = ld_hi_data;
      if (ld_lo) lo_d = ld_lo_data;
    end else if (vld_q) begin
      hi_d   = clip_hi;
      lo_d   = clip_lo;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (acc_en) begin
        hi_q <= hi_d;
        lo_q <= lo_d;
      end
    end
  end

  assign done   = done_q;
  assign acc_hi = hi_q;
  assign acc_lo = lo_q;

  assert_done_after_start_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> $past(start, 2));

  assert_clear_zeroes_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clr |=> (acc_hi == '0 && acc_lo == '0 && !done));

  assert_load_hi_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ld_hi && !clr) |=> (acc_hi == $past(ld_hi_data) && !done));

  assert_load_lo_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ld_lo && !clr) |=> (acc_lo == $past(ld_lo_data) && !done));

  assert_long_band_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && !$past(op_sel, 2) && $past(sat_en, 2)) |->
      ((acc_hi[DATA_W-1:HALF_W] == '1) || (acc_hi[DATA_W-1:HALF_W-1] == '0)));

  assert_word_high_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && $past(op_sel, 2) && $past(sat_en, 2)) |->
      (acc_hi == '0 || acc_hi == '1 || acc_hi == DATA_W'(1)));
endmodule

// File: tb/test_sat_mac_unit.sv
`timescale 1ns/1ps
module test_sat_mac_unit;
  localparam int DW = 8;
  localparam int HW = DW / 2;
  localparam longint AMOD = 64'sd1 << (2 * DW);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start, op_sel, sat_en, clr, ld_hi, ld_lo;
  logic [DW-1:0] opnd_a, opnd_b, ld_hi_data, ld_lo_data;
  logic          done;
  logic [DW-1:0] acc_hi, acc_lo;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sat_mac_unit #(.DATA_W(DW)) i_sat_mac_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .sat_en(sat_en),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .clr(clr), .ld_hi(ld_hi), .ld_lo(ld_lo),
    .ld_hi_data(ld_hi_data), .ld_lo_data(ld_lo_data),
    .done(done), .acc_hi(acc_hi), .acc_lo(acc_lo)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic longint sext(input longint v, input int w);
    longint m;
    m = v & ((64'sd1 << w) - 1);
    return m[w-1] ? m - (64'sd1 << w) : m;
  endfunction

  function automatic void model(input bit op, input bit sat, input logic [DW-1:0] a,
                                input logic [DW-1:0] b, input logic [2*DW-1:0] acc,
                                output logic [2*DW-1:0] res, output string tag);
    longint sa, sb, sum, ss;
    logic [DW-1:0] hi, lo;
    int w;
    w   = op ? HW : DW;
    sa  = sext(longint'(a), w);
    sb  = sext(longint'(b), w);
    sum = (longint'(acc) + sa * sb) % AMOD;
    if (sum < 0) sum = sum + AMOD;
    ss  = (sum >= AMOD / 2) ? sum - AMOD : sum;
    hi  = DW'(sum >> DW);
    lo  = DW'(sum);
    tag = op ? "R3" : "R2";
    if (sat && !op) begin
      if (ss < 0) begin hi = hi | {{HW{1'b1}}, {HW{1'b0}}}; tag = "R5"; end
      else        begin hi = hi & {{(HW+1){1'b0}}, {(HW-1){1'b1}}}; tag = "R6"; end
    end else if (sat && op) begin
      if (ss < -(64'sd1 << (DW-1))) begin
        hi = DW'(1); lo = {1'b1, {(DW-1){1'b0}}}; tag = "R7";
      end else begin
        tag = "R8";
        if (ss > (64'sd1 << (DW-1)) - 1) begin hi = DW'(1); lo = {1'b0, {(DW-1){1'b1}}}; end
      end
    end
    res = {hi, lo};
  endfunction

  task automatic idle_inputs();
    start = 0; op_sel = 0; sat_en = 0; clr = 0; ld_hi = 0; ld_lo = 0;
    opnd_a = '0; opnd_b = '0; ld_hi_data = '0; ld_lo_data = '0;
  endtask

  // called at a negedge: seeds the accumulator and issues one operation together
  task automatic run_op(input bit op, input bit sat, input logic [DW-1:0] a,
                        input logic [DW-1:0] b, input logic [2*DW-1:0] seed);
    logic [2*DW-1:0] exp;
    string tag;
    model(op, sat, a, b, seed, exp, tag);
    ld_hi = 1; ld_lo = 1; ld_hi_data = seed[2*DW-1:DW]; ld_lo_data = seed[DW-1:0];
    start = 1; op_sel = op; sat_en = sat; opnd_a = a; opnd_b = b;
    @(negedge clk);
    chk("R4 done low before result", done, 0);
    idle_inputs();
    @(negedge clk);
    chk("R4 done pulse", done, 1);
    chk(tag, {acc_hi, acc_lo}, exp);
  endtask

  initial begin
    logic [2*DW-1:0] seeds_w [4];
    logic [2*DW-1:0] seeds_l [4];
    seeds_w = '{16'h0000, 16'h007E, 16'hFF81, 16'h0100};
    seeds_l = '{16'h0000, 16'h7FF0, 16'h8010, 16'hFFFF};
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 acc_hi", acc_hi, 0);
    chk("R1 acc_lo", acc_lo, 0);
    chk("R1 done", done, 0);

    // word operation sweep: every low-half pair, garbage in upper operand bits
    for (int a = 0; a < 256; a++)
      for (int bl = 0; bl < 16; bl++)
        for (int s = 0; s < 2; s++)
          run_op(1'b1, s[0], DW'(a), DW'(((a * 7) & 8'hF0) | bl), seeds_w[(a ^ bl ^ s) & 3]);

    // long operation sweep over a strided grid
    for (int a = 0; a < 256; a += 3)
      for (int b = 0; b < 256; b += 7)
        for (int s = 0; s < 2; s++)
          run_op(1'b0, s[0], DW'(a), DW'(b), seeds_l[(a + b + s) & 3]);

    // R4 back-to-back accumulation: 3*4=12, then -2*5 -> 2, then 10*10 -> 102
    clr = 1; start = 1; op_sel = 0; opnd_a = 8'd3; opnd_b = 8'd4;
    @(negedge clk);
    clr = 0; opnd_a = 8'hFE; opnd_b = 8'd5;
    @(negedge clk);
    opnd_a = 8'd10; opnd_b = 8'd10;
    chk("R4 stream done 1", done, 1);
    chk("R4 stream acc 1", {acc_hi, acc_lo}, 12);
    @(negedge clk);
    idle_inputs();
    chk("R4 stream done 2", done, 1);
    chk("R4 stream acc 2", {acc_hi, acc_lo}, 2);
    @(negedge clk);
    chk("R4 stream done 3", done, 1);
    chk("R4 stream acc 3", {acc_hi, acc_lo}, 102);
    @(negedge clk);
    chk("R4 single-cycle done", done, 0);

    // R10 load collides with accumulate writeback
    ld_hi = 1; ld_lo = 1; ld_hi_data = 8'h12; ld_lo_data = 8'h34;
    @(negedge clk);
    idle_inputs(); start = 1; opnd_a = 8'd2; opnd_b = 8'd3;
    @(negedge clk);
    idle_inputs(); ld_lo = 1; ld_lo_data = 8'h55;
    @(negedge clk);
    idle_inputs();
    chk("R10 hi kept", acc_hi, 8'h12);
    chk("R10 lo loaded", acc_lo, 8'h55);
    chk("R10 done suppressed", done, 0);
    @(negedge clk);
    chk("R10 accumulate discarded", {acc_hi, acc_lo}, 16'h1255);

    // R9 clear beats load and accumulate
    start = 1; opnd_a = 8'd5; opnd_b = 8'd5;
    @(negedge clk);
    idle_inputs(); clr = 1; ld_hi = 1; ld_hi_data = 8'h77;
    @(negedge clk);
    idle_inputs();
    chk("R9 cleared", {acc_hi, acc_lo}, 0);
    chk("R9 done suppressed", done, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule